// File: doc/BRIEF.md
# Packed Vector Float/Integer Lane Converter

This unit converts each 32-bit lane of a packed vector between IEEE-754 single precision and 32-bit integers. A two-bit operation code picks the conversion: signed integer to float, unsigned integer to float, float to signed integer, or float to unsigned integer. Conversions to integer discard the fraction, rounding toward zero. Conversions to float round to nearest, with ties going to even. A width select chooses between a full vector of four lanes and a half vector of two lanes.

Every lane is converted in parallel in one combinational stage. The results land in an output register one clock after a valid input, and the output valid strobe follows the input strobe by that same clock. Two sticky flags collect exception events from every accepted operation: invalid (out-of-range or NaN sources) and inexact (discarded nonzero bits). The flags clear only on reset.

Top module: `vec_cvt`

## Requirements
- R1: Lane i occupies bits [32i+31:32i]. Op code 2'b00 converts each lane from a two's-complement signed integer to single precision, rounding to nearest with ties to even; a zero lane gives 0x00000000.
- R2: Op code 2'b01 converts each lane from an unsigned integer to single precision with the same rounding, so a pattern with bit 31 set gives a positive result, unlike op 2'b00.
- R3: Op code 2'b10 converts single precision to a signed integer, truncating toward zero (2.5 gives 2, -2.5 gives -2).
- R4: Op code 2'b11 converts single precision to an unsigned integer, truncating toward zero.
- R5: A float-to-integer source beyond the destination range, infinities included, saturates toward its sign (signed: 0x7FFFFFFF or 0x80000000; unsigned: 0xFFFFFFFF or 0) and sets the invalid flag; saturation does not set inexact.
- R6: A NaN source in a float-to-integer conversion gives 0 and sets the invalid flag.
- R7: A float-to-integer source of magnitude below one, denormals included, gives 0 without setting invalid, and sets inexact when the source is nonzero. This covers negative sources in float-to-unsigned mode.
- R8: Float-to-integer with a nonzero discarded fraction, and integer-to-float where a discarded low-order bit is nonzero, set the inexact flag; exact conversions leave it clear.
- R9: With in_wide = 1 all four lanes are converted; with in_wide = 0 only lanes 0 and 1 are converted, bits [127:64] of the result are zero, and lanes 2 and 3 do not affect the flags.
- R10: out_valid equals in_valid delayed by one clock; out_vec is loaded at the edge where in_valid is high and holds its value otherwise.
- R11: Reset clears out_vec, out_valid and both flags; afterwards each flag stays set once set, until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Conversion select (see R1-R4 encoding) |
| in_wide | input | 1 | 1: four lanes, 0: two lanes |
| in_vec | input | 128 | Source vector |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_vec | output | 128 | Registered result vector |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
The only state is the output register and the two sticky flags, so a fault shows in the very next result. A wrong rounding or saturation decision shows as a wrong lane value one clock after the strobe. A flag that clears or sets spuriously shows on the flag pins at that same edge and persists until reset. A stale or half-updated output register shows as a mismatch on out_vec in the cycle after any strobe, or as a change of out_vec in a cycle with no strobe.

// File: rtl/vec_cvt.sv
module vec_cvt #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            in_op,
  input  logic                  in_wide,
  input  logic [LANES*32-1:0]   in_vec,
  output logic                  out_valid,
  output logic [LANES*32-1:0]   out_vec,
  output logic                  flag_invalid,
  output logic                  flag_inexact
);
  localparam int VW   = LANES * 32;
  localparam int HALF = LANES / 2;

  // returns {invalid, inexact, result}
  function automatic logic [33:0] flt2int(input logic [31:0] f, input logic uns);
    logic        s;
    logic [7:0]  ex;
    logic [23:0] man;
    logic [54:0] sh;
    logic [31:0] mag;
    logic        big, frac;
    s   = f[31];
    ex  = f[30:23];
    man = {ex != 8'd0, f[22:0]};
    sh  = '0;
    mag = '0;
    frac = 1'b0;
    if (ex == 8'hFF && f[22:0] != 23'd0) return {2'b10, 32'h0};
    if (ex < 8'd127) return {1'b0, (ex != 8'd0 || f[22:0] != 23'd0), 32'h0};
    big = ex >= 8'd159;
    if (!big) begin
      sh   = {31'h0, man} << (ex - 8'd127);
      mag  = sh[54:23];
      frac = sh[22:0] != 23'd0;
    end
    if (uns) begin
      if (s)   return {2'b10, 32'h0};
      if (big) return {2'b10, 32'hFFFF_FFFF};
      return {1'b0, frac, mag};
    end
    if (big || (!s && mag[31]) || (s && mag > 32'h8000_0000))
      return {2'b10, s ? 32'h8000_0000 : 32'h7FFF_FFFF};
    return {1'b0, frac, s ? -mag : mag};
  endfunction

  function automatic logic [33:0] int2flt(input logic [31:0] x, input logic uns);
    logic        s, guard, stk, rnd;
    logic [31:0] mag;
    logic [4:0]  p, sa;
    logic [7:0]  ex;
    logic [22:0] keep;
    s   = !uns && x[31];
    mag = s ? -x : x;
    p   = 5'd0;
    if (mag == 32'd0) return 34'd0;
    for (int i = 0; i < 32; i++)
      if (mag[i]) p = 5'(i);
    ex = 8'd127 + {3'b0, p};
    if (p <= 5'd23) begin
      keep = 23'(mag << (5'd23 - p));
      return {2'b00, s, ex, keep};
    end
    sa    = p - 5'd23;
    keep  = 23'(mag >> sa);
    guard = mag[sa - 5'd1];
    stk   = (mag & ((32'h1 << (sa - 5'd1)) - 32'h1)) != 32'd0;
    rnd   = guard && (stk || keep[0]);
    return {1'b0, guard | stk, {s, ex, keep} + {31'h0, rnd}};
  endfunction

  logic [VW-1:0]    res;
  logic [LANES-1:0] inv_l, inx_l;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [33:0] conv;
    logic        act;
    assign act  = in_wide || (i < HALF);
    assign conv = in_op[1] ? flt2int(in_vec[i*32 +: 32], in_op[0])
                           : int2flt(in_vec[i*32 +: 32], in_op[0]);
    assign res[i*32 +: 32] = act ? conv[31:0] : 32'h0;
    assign inv_l[i] = act && conv[33];
    assign inx_l[i] = act && conv[32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_vec      <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec      <= res;
        flag_invalid <= flag_invalid | (|inv_l);
        flag_inexact <= flag_inexact | (|inx_l);
      end
    end
  end
endmodule

// File: rtl/vec_cvt_chk.sv
module vec_cvt_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          in_op,
  input logic                in_wide,
  input logic [LANES*32-1:0] in_vec,
  input logic                out_valid,
  input logic [LANES*32-1:0] out_vec,
  input logic                flag_invalid,
  input logic                flag_inexact
);
  localparam int VW = LANES * 32;

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));
  p_narrow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_wide |=> out_vec[VW-1:VW/2] == '0);
  p_sticky_inv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |=> flag_invalid);
  p_sticky_inx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inexact |=> flag_inexact);
  p_zero_int_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == 2'b00 && in_vec[31:0] == 32'h0 |=> out_vec[31:0] == 32'h0);
endmodule

bind vec_cvt vec_cvt_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_wide(in_wide), .in_vec(in_vec), .out_valid(out_valid),
  .out_vec(out_vec), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
);

// File: tb/test_vec_cvt.sv
module test_vec_cvt;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // {op, wide, source, expected}
  localparam logic [258:0] TBL [NV] = '{
    {2'b00, 1'b1, 128'h01000001_00000000_FFFFFFFF_00000001, 128'h4B800000_00000000_BF800000_3F800000},
    {2'b01, 1'b1, 128'h01000003_00000003_80000000_FFFFFFFF, 128'h4B800002_40400000_4F000000_4F800000},
    {2'b10, 1'b1, 128'h4F000000_BF400000_C0200000_40200000, 128'h7FFFFFFF_00000000_FFFFFFFE_00000002},
    {2'b11, 1'b1, 128'h40FC0000_BF800000_4F7FFFFF_4F800000, 128'h00000007_00000000_FFFFFF00_FFFFFFFF},
    {2'b10, 1'b0, 128'h3F800000_3F800000_7F800000_CF000000, 128'h00000000_00000000_7FFFFFFF_80000000},
    {2'b00, 1'b0, 128'h00000005_00000006_7FFFFFFF_80000000, 128'h00000000_00000000_4F000000_CF000000},
    {2'b11, 1'b1, 128'h3F800000_FF800000_00000001_7FC00000, 128'h00000001_00000000_00000000_00000000}
  };
  localparam string TAGS [NV] = '{"R1 R2", "R2 R8", "R3 R5 R7", "R4 R5 R7",
                                  "R9 R5 R3", "R9 R1", "R6 R7 R5"};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_wide = 1'b1;
  logic [1:0] in_op = 2'b00;
  logic [127:0] in_vec = '0;
  logic out_valid, flag_invalid, flag_inexact;
  logic [127:0] out_vec;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_cvt i_vec_cvt (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_wide(in_wide), .in_vec(in_vec), .out_valid(out_valid), .out_vec(out_vec),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact));

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic apply(input logic [1:0] op, input logic wide, input logic [127:0] v);
    @(negedge clk);
    in_op = op; in_wide = wide; in_vec = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic flags(input string tag, input logic [1:0] op, input logic wide,
                       input logic [127:0] v, input logic ei, input logic ex);
    do_reset();
    apply(op, wide, v);
    check(tag, {126'h0, flag_invalid, flag_inexact}, {126'h0, ei, ex});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R11 reset state", {out_vec[125:0], out_valid, flag_invalid | flag_inexact}, 128'h0);

    for (int k = 0; k < NV; k++) begin
      apply(TBL[k][258:257], TBL[k][256], TBL[k][255:128]);
      check(TAGS[k], out_vec, TBL[k][127:0]);
    end

    // R10 latency and hold
    do_reset();
    @(negedge clk);
    in_op = 2'b10; in_wide = 1'b1; in_vec = {4{32'h40400000}}; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 valid after strobe", {127'h0, out_valid}, 128'h1);
    check("R10 result loaded", out_vec, {4{32'h3}});
    in_vec = {4{32'h41200000}};
    @(negedge clk);
    check("R10 valid drops", {127'h0, out_valid}, 128'h0);
    check("R10 hold without strobe", out_vec, {4{32'h3}});

    flags("R8 exact f2i", 2'b10, 1'b1, {4{32'h40000000}}, 1'b0, 1'b0);
    flags("R8 inexact f2i", 2'b10, 1'b1, {96'h0, 32'h40200000}, 1'b0, 1'b1);
    flags("R6 nan invalid", 2'b10, 1'b1, {96'h0, 32'h7FC00000}, 1'b1, 1'b0);
    flags("R7 denormal", 2'b10, 1'b1, {96'h0, 32'h00000001}, 1'b0, 1'b1);
    flags("R7 neg small unsigned", 2'b11, 1'b1, {96'h0, 32'hBF000000}, 1'b0, 1'b1);
    flags("R5 saturate flags", 2'b11, 1'b1, {96'h0, 32'hBF800000}, 1'b1, 1'b0);
    flags("R8 i2f tie inexact", 2'b00, 1'b1, {96'h0, 32'h01000001}, 1'b0, 1'b1);
    flags("R8 i2f exact", 2'b00, 1'b1, {96'h0, 32'h01000000}, 1'b0, 1'b0);
    flags("R9 upper lanes ignored", 2'b10, 1'b0,
          {32'h7FC00000, 32'h7FC00000, 32'h3F800000, 32'h3F800000}, 1'b0, 1'b0);

    // R11 stickiness
    flags("R11 set", 2'b10, 1'b1, {96'h0, 32'h7FC00000}, 1'b1, 1'b0);
    apply(2'b10, 1'b1, {4{32'h3F800000}});
    check("R11 invalid sticky", {127'h0, flag_invalid}, 128'h1);
    check("R3 after sticky", out_vec, {4{32'h1}});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule